// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block makes the keep-or-drop decision for every frame coming out of an Ethernet receive MAC. At the end-of-frame strobe it takes the frame's byte count, its CRC, extra-nibble and code-violation flags, and the address-match verdict. It combines these with a programmable length ceiling and five policy bits. One cycle later it emits a single verdict: accept, or discard. A discarded frame can also be reported to the host, while its buffers are still handed back for reuse. Alongside the verdict it raises one-cycle pulses that the statistics counters use, one for each error class.

With every policy bit clear, a frame is kept only when it matched the address filter, carries no error flag, and holds between the minimum length and the ceiling inclusive. Separate override bits relax one rule each: CRC-only faults, any symbol-level fault, over-long frames and runt frames. Address matching always wins. A frame that missed the address filter is dropped silently and is not counted. Address matching, CRC computation and DMA lie outside this block.

Top module: `rx_accept_filter`

## Requirements
- R1: With all policy bits clear and the address matched, a frame with no error flag and a byte count from MIN_LEN (64) to the ceiling inclusive is accepted.
- R2: With all policy bits clear, a frame shorter than MIN_LEN or longer than the ceiling is discarded, even if it has no error flag.
- R3: A max_len input of zero selects the default ceiling DEF_MAX_LEN (1536). Any other value is used as the ceiling as given.
- R4: When allow_crc is set, a frame whose only error flag is crc_err is not rejected for that flag. A frame that also has nib_err or code_err is still rejected unless allow_bad is set.
- R5: When allow_long is set, frames longer than the ceiling are not rejected for their length.
- R6: When allow_bad is set, any mix of crc_err, nib_err and code_err does not cause rejection.
- R7: When allow_short is set, frames shorter than MIN_LEN are not rejected for their length.
- R8: report is raised together with discard for an address-matched rejected frame that is over-long or has an error flag, but only while report_bad is set. A rejection caused only by shortness is never reported. report is never raised with accept.
- R9: A frame whose addr_hit is low is discarded. For it, report and all statistics pulses stay low, whatever the policy bits say.
- R10: The verdict appears in the cycle after the eof edge and lasts one cycle, with exactly one of accept and discard high. In every other cycle, accept, discard, report and the statistics pulses are low.
- R11: For an address-matched frame, the verdict cycle also carries the statistics pulses, regardless of acceptance. stat_crc follows crc_err. stat_len is high if the frame is short or long. stat_sym is high if nib_err or code_err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof | input | 1 | End-of-frame strobe; frame status is valid in this cycle |
| byte_cnt | input | LEN_W | Received frame length in bytes |
| crc_err | input | 1 | Frame check sequence mismatch |
| nib_err | input | 1 | Extra nibble or dribble bits |
| code_err | input | 1 | Line code violation |
| addr_hit | input | 1 | Address filter matched this frame |
| max_len | input | LEN_W | Length ceiling; zero selects DEF_MAX_LEN |
| allow_crc | input | 1 | Accept CRC-only faults |
| allow_long | input | 1 | Accept frames over the ceiling |
| allow_bad | input | 1 | Accept any CRC, nibble or code fault |
| allow_short | input | 1 | Accept runt frames |
| report_bad | input | 1 | Report long and errored rejects to the host |
| accept | output | 1 | Frame kept |
| discard | output | 1 | Frame dropped, buffers recycled |
| report | output | 1 | Status of a dropped frame goes to the host |
| stat_crc | output | 1 | CRC error count pulse |
| stat_len | output | 1 | Length error count pulse |
| stat_sym | output | 1 | Nibble or code error count pulse |

## Verification
The assertions check the framing of the verdict on every cycle. Outputs appear only in the cycle after eof, accept and discard are exclusive, report never appears without discard, and an address miss yields a silent discard with no counts. Whether a particular mix of length, flags and policy bits gives the right verdict can only be shown by the bench scenarios. These compare each frame against a reference model, with directed frames at the length boundaries of 63, 64, the ceiling and the ceiling plus one, and with the zero-ceiling default.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef struct packed {
      logic accept;
      logic discard;
      logic report;
      logic stat_crc;
      logic stat_len;
      logic stat_sym;
   } rxf_verdict_t;

   localparam rxf_verdict_t RXF_IDLE = '0;

endpackage

// File: rtl/rxf_len_check.sv
module rxf_len_check #(
   parameter int LEN_W       = 14,
   parameter int MIN_LEN     = 64,
   parameter int DEF_MAX_LEN = 1536,
   parameter bit ZERO_IS_DEF = 1'b1
) (
   input  logic [LEN_W-1:0] byte_cnt,
   input  logic [LEN_W-1:0] max_len,
   output logic             is_short,
   output logic             is_long
);
   localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] DEF_V = LEN_W'(DEF_MAX_LEN);

   logic [LEN_W-1:0] ceiling;

   generate
      if (ZERO_IS_DEF) begin : g_zero_def
         assign ceiling = (max_len == '0) ? DEF_V : max_len;
      end else begin : g_raw_ceiling
         assign ceiling = max_len;
      end

      if (MIN_LEN == 0) begin : g_no_min
         assign is_short = 1'b0;
      end else begin : g_min
         assign is_short = byte_cnt < MIN_V;
      end
   endgenerate

   assign is_long = byte_cnt > ceiling;

endmodule

// File: rtl/rxf_err_class.sv
module rxf_err_class (
   input  logic crc_err,
   input  logic nib_err,
   input  logic code_err,
   input  logic allow_crc,
   input  logic allow_bad,
   output logic sym_fault,
   output logic any_fault,
   output logic flags_ok
);
   logic crc_only;

   assign sym_fault = nib_err | code_err;
   assign any_fault = crc_err | sym_fault;
   assign crc_only  = crc_err & ~sym_fault;
   assign flags_ok  = ~any_fault | allow_bad | (allow_crc & crc_only);

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
   import rxf_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         eof,
   input  logic         addr_hit,
   input  logic         len_ok,
   input  logic         flags_ok,
   input  logic         is_long,
   input  logic         is_short,
   input  logic         crc_err,
   input  logic         sym_fault,
   input  logic         any_fault,
   input  logic         report_bad,
   output rxf_verdict_t verdict
);
   rxf_verdict_t nxt;
   logic         keep;

   always_comb begin
      keep = addr_hit & len_ok & flags_ok;
      nxt  = RXF_IDLE;
      if (eof) begin
         nxt.accept  = keep;
         nxt.discard = ~keep;
         if (addr_hit) begin
            nxt.report   = ~keep & report_bad & (is_long | any_fault);
            nxt.stat_crc = crc_err;
            nxt.stat_len = is_short | is_long;
            nxt.stat_sym = sym_fault;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) verdict <= RXF_IDLE;
      else        verdict <= nxt;
   end

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
   import rxf_pkg::*;
#(
   parameter int LEN_W       = 14,
   parameter int MIN_LEN     = 64,
   parameter int DEF_MAX_LEN = 1536,
   parameter bit ZERO_IS_DEF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eof,
   input  logic [LEN_W-1:0] byte_cnt,
   input  logic             crc_err,
   input  logic             nib_err,
   input  logic             code_err,
   input  logic             addr_hit,
   input  logic [LEN_W-1:0] max_len,
   input  logic             allow_crc,
   input  logic             allow_long,
   input  logic             allow_bad,
   input  logic             allow_short,
   input  logic             report_bad,
   output logic             accept,
   output logic             discard,
   output logic             report,
   output logic             stat_crc,
   output logic             stat_len,
   output logic             stat_sym
);
   generate
      if (LEN_W < 2 || LEN_W > 24) begin : g_bad_width
         $error("rx_accept_filter: LEN_W out of range");
      end
      if (DEF_MAX_LEN >= (1 << LEN_W) || DEF_MAX_LEN < MIN_LEN) begin : g_bad_max
         $error("rx_accept_filter: DEF_MAX_LEN does not fit");
      end
      if (MIN_LEN < 0 || MIN_LEN >= (1 << LEN_W)) begin : g_bad_min
         $error("rx_accept_filter: MIN_LEN does not fit");
      end
   endgenerate

   logic is_short, is_long, len_ok;
   logic sym_fault, any_fault, flags_ok;
   rxf_verdict_t verdict;

   rxf_len_check #(
      .LEN_W(LEN_W), .MIN_LEN(MIN_LEN),
      .DEF_MAX_LEN(DEF_MAX_LEN), .ZERO_IS_DEF(ZERO_IS_DEF)
   ) u_len (
      .byte_cnt(byte_cnt), .max_len(max_len),
      .is_short(is_short), .is_long(is_long)
   );

   rxf_err_class u_err (
      .crc_err(crc_err), .nib_err(nib_err), .code_err(code_err),
      .allow_crc(allow_crc), .allow_bad(allow_bad),
      .sym_fault(sym_fault), .any_fault(any_fault), .flags_ok(flags_ok)
   );

   assign len_ok = (~is_short | allow_short) & (~is_long | allow_long);

   rxf_verdict u_verdict (
      .clk(clk), .rst_n(rst_n), .eof(eof), .addr_hit(addr_hit),
      .len_ok(len_ok), .flags_ok(flags_ok),
      .is_long(is_long), .is_short(is_short),
      .crc_err(crc_err), .sym_fault(sym_fault), .any_fault(any_fault),
      .report_bad(report_bad), .verdict(verdict)
   );

   assign accept   = verdict.accept;
   assign discard  = verdict.discard;
   assign report   = verdict.report;
   assign stat_crc = verdict.stat_crc;
   assign stat_len = verdict.stat_len;
   assign stat_sym = verdict.stat_sym;

   // R10
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eof) && $past(rst_n) |-> (accept ^ discard));

   // R10
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eof) |-> !(accept | discard | report | stat_crc | stat_len | stat_sym));

   // R8
   report_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      report |-> discard && !accept);

   // R9
   miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eof) && !$past(addr_hit) && $past(rst_n)
         |-> discard && !report && !stat_crc && !stat_len && !stat_sym);

   // R11
   crc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_crc |-> $past(crc_err) && $past(addr_hit));

   // R6
   bad_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eof) && $past(rst_n) && $past(addr_hit) && $past(allow_bad)
         && $past(allow_long) && $past(allow_short) |-> accept);

endmodule

// File: tb/tb_rx_accept_filter.sv
module tb_rx_accept_filter;
   localparam int LW = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eof = 1'b0;
   logic [LW-1:0] byte_cnt = '0;
   logic crc_err = 0, nib_err = 0, code_err = 0, addr_hit = 0;
   logic [LW-1:0] max_len = '0;
   logic allow_crc = 0, allow_long = 0, allow_bad = 0, allow_short = 0, report_bad = 0;
   logic accept, discard, report, stat_crc, stat_len, stat_sym;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rx_accept_filter dut (
      .clk(clk), .rst_n(rst_n), .eof(eof), .byte_cnt(byte_cnt),
      .crc_err(crc_err), .nib_err(nib_err), .code_err(code_err),
      .addr_hit(addr_hit), .max_len(max_len),
      .allow_crc(allow_crc), .allow_long(allow_long), .allow_bad(allow_bad),
      .allow_short(allow_short), .report_bad(report_bad),
      .accept(accept), .discard(discard), .report(report),
      .stat_crc(stat_crc), .stat_len(stat_len), .stat_sym(stat_sym)
   );

   // Reference: {accept, discard, report, stat_crc, stat_len, stat_sym}
   function automatic logic [5:0] model(input int cnt, input bit c, input bit n,
         input bit v, input bit hit, input int mx, input bit ac, input bit al,
         input bit ab, input bit as, input bit rb);
      int  lim = (mx == 0) ? 1536 : mx;
      bit  shrt = cnt < 64;
      bit  lng = cnt > lim;
      bit  flags_fine = !(c || n || v) || ab || (ac && c && !n && !v);
      bit  size_fine = (!shrt || as) && (!lng || al);
      bit  ok = hit && flags_fine && size_fine;
      bit  rp = hit && !ok && rb && (lng || c || n || v);
      if (!hit) return 6'b010000;
      return {ok, !ok, rp, c, shrt || lng, n || v};
   endfunction

   task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic frame(input string req, input int cnt, input bit c, input bit n,
         input bit v, input bit hit, input int mx, input logic [4:0] pol);
      logic [5:0] exp;
      @(negedge clk);
      byte_cnt = LW'(cnt); crc_err = c; nib_err = n; code_err = v;
      addr_hit = hit; max_len = LW'(mx);
      {allow_crc, allow_long, allow_bad, allow_short, report_bad} = pol;
      eof = 1'b1;
      exp = model(cnt, c, n, v, hit, mx, pol[4], pol[3], pol[2], pol[1], pol[0]);
      @(negedge clk);
      eof = 1'b0;
      check(req, {accept, discard, report, stat_crc, stat_len, stat_sym}, exp);
      @(negedge clk);
      // R10: nothing in the cycle after the verdict
      check("R10 idle", {accept, discard, report, stat_crc, stat_len, stat_sym}, 6'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R10 reset", {accept, discard, report, stat_crc, stat_len, stat_sym}, 6'b0);
      rst_n = 1'b1;

      frame("R1 clean min",    64,   0,0,0, 1, 0,    5'b00000);
      frame("R1 clean max",    1536, 0,0,0, 1, 0,    5'b00000);
      frame("R2 runt",         63,   0,0,0, 1, 0,    5'b00000);
      frame("R2 long",         1537, 0,0,0, 1, 0,    5'b00000);
      frame("R3 custom max",   1000, 0,0,0, 1, 1000, 5'b00000);
      frame("R3 custom over",  1001, 0,0,0, 1, 1000, 5'b00000);
      frame("R3 default over", 1600, 0,0,0, 1, 0,    5'b00000);
      frame("R4 crc only",     500,  1,0,0, 1, 0,    5'b10000);
      frame("R4 crc plus nib", 500,  1,1,0, 1, 0,    5'b10000);
      frame("R5 long allowed", 3000, 0,0,0, 1, 0,    5'b01000);
      frame("R6 code allowed", 300,  0,0,1, 1, 0,    5'b00100);
      frame("R6 all flags",    300,  1,1,1, 1, 0,    5'b00100);
      frame("R7 runt allowed", 10,   0,0,0, 1, 0,    5'b00010);
      frame("R8 long report",  2000, 0,0,0, 1, 0,    5'b00001);
      frame("R8 crc report",   200,  1,0,0, 1, 0,    5'b00001);
      frame("R8 runt no rpt",  20,   0,0,0, 1, 0,    5'b00001);
      frame("R8 no report",    2000, 0,0,0, 1, 0,    5'b00000);
      frame("R9 miss",         200,  1,1,1, 0, 0,    5'b11111);
      frame("R9 miss clean",   200,  0,0,0, 0, 0,    5'b00000);
      frame("R11 all classes", 40,   1,0,1, 1, 0,    5'b00000);

      for (int i = 0; i < 400; i++) begin
         int sel = $urandom_range(0, 5);
         int mx  = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(64, 4000);
         int lim = (mx == 0) ? 1536 : mx;
         int cnt;
         case (sel)
            0: cnt = $urandom_range(62, 65);
            1: cnt = lim - 1 + $urandom_range(0, 2);
            2: cnt = $urandom_range(0, 63);
            default: cnt = $urandom_range(0, 16383);
         endcase
         if (cnt > 16383) cnt = 16383;
         frame("R11 random", cnt, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0),
               mx, 5'($urandom_range(0, 31)));
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule